// File: doc/BRIEF.md
# Quadrant-Differential QAM Symbol Encoder

This block turns groups of data bits into signed in-phase and quadrature sample pairs for a two-wire low-speed modem transmitter. It keeps the current constellation quadrant as state. On each accepted symbol, the leading dibit rotates that quadrant by a multiple of 90 degrees.

At the highest rate, a trailing dibit then picks one of four points inside the quadrant that was reached. At the two lower rates, the block always sends the innermost point of the new quadrant. The caller presents a symbol together with a valid strobe and a rate code. One cycle later the block presents the scaled I and Q bytes with an output valid.

Top module: `qam_quadrant_encoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0, `i_out` and `q_out` are 0, and the stored quadrant is quadrant 1 (positive I, positive Q).
- R2: Rate code `rate_sel` 2'b10 (4 bits per symbol) and 2'b01 (2 bits per symbol) advance the quadrant counterclockwise by a step set by the leading dibit. That dibit is `sym_bits[3:2]` at 2'b10 and `sym_bits[1:0]` at 2'b01. Dibit 00 steps 1 quadrant, 01 steps 0, 10 steps 2 and 11 steps 3, and the step wraps from quadrant 4 to quadrant 1.
- R3: At rate code 2'b00 (1 bit per symbol), `sym_bits[0]`=0 steps the quadrant by 1 and `sym_bits[0]`=1 steps it by 3. `sym_bits[3:1]` have no effect.
- R4: At rate code 2'b10, `sym_bits[1:0]` choose the unit point in quadrant 1: 01→(1,1), 00→(3,1), 11→(1,3), 10→(3,3). For quadrant n, that point is rotated counterclockwise by (n-1)×90 degrees, using (x,y)→(−y,x) for each step.
- R5: At rate codes 2'b00 and 2'b01, the unit point sent is always (1,1) rotated into the new quadrant.
- R6: `i_out` and `q_out` are two's complement and equal the unit coordinates multiplied by 30, so each is one of ±30 or ±90.
- R7: A symbol with `sym_valid` high at a clock edge and an accepted rate code gives `out_valid`=1 on the next cycle. On that same cycle, `i_out`/`q_out` hold the point of the updated quadrant.
- R8: With `sym_valid` low, the quadrant does not change, `out_valid` is 0 on the following cycle, and `i_out`/`q_out` keep their values.
- R9: Rate code 2'b11 is reserved. A strobed symbol with that code leaves the quadrant unchanged and produces no `out_valid`.
- R10: At rate code 2'b01, `sym_bits[3:2]` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Symbol strobe |
| rate_sel | input | 2 | Rate code: 00 one bit, 01 two bits, 10 four bits, 11 reserved |
| sym_bits | input | 4 | Symbol bits, with the leading dibit in the high pair at rate 10 |
| out_valid | output | 1 | New I/Q sample present |
| i_out | output | 8 | In-phase coordinate, two's complement |
| q_out | output | 8 | Quadrature coordinate, two's complement |

## Verification
The bench feeds every 4-bit symbol at every rate code, with a matching model of the stored quadrant, so each quadrant is entered from every other quadrant under every step code. A wrong entry in the step table, or a wrap that misses the step from quadrant 4 to quadrant 1, leaves the quadrant skewed, and the error shows in the signs of all later samples. A rotation that goes clockwise, or that swaps the 00 and 11 inner points, produces the right magnitudes on the wrong axes. If the unused high bits leak in at the lower rates, or the reserved rate moves the quadrant, the mismatch appears on the next sample.

// File: rtl/qam_enc_pkg.sv
package qam_enc_pkg;
  typedef enum logic [1:0] {
    RATE_1BIT  = 2'b00,
    RATE_2BIT  = 2'b01,
    RATE_4BIT  = 2'b10,
    RATE_RSVD  = 2'b11
  } rate_e;

  localparam int QUAD_W = 2;
  typedef logic [QUAD_W-1:0] quad_t;

  // dibit to counterclockwise quadrant step
  function automatic quad_t dibit_step(input logic [1:0] d);
    case (d)
      2'b00:   dibit_step = 2'd1;
      2'b01:   dibit_step = 2'd0;
      2'b10:   dibit_step = 2'd2;
      default: dibit_step = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/qam_quad_step.sv
module qam_quad_step
  import qam_enc_pkg::*;
#(
  parameter int SYM_W = 4
) (
  input  rate_e            rate,
  input  logic [SYM_W-1:0] sym,
  output quad_t            step,
  output logic             accept,
  output logic             fine
);
  always_comb begin
    step   = '0;
    accept = 1'b1;
    fine   = 1'b0;
    case (rate)
      RATE_1BIT: step = sym[0] ? 2'd3 : 2'd1;
      RATE_2BIT: step = dibit_step(sym[1:0]);
      RATE_4BIT: begin
        step = dibit_step(sym[SYM_W-1:SYM_W-2]);
        fine = 1'b1;
      end
      default:   accept = 1'b0;
    endcase
  end
endmodule

// File: rtl/qam_quad_tracker.sv
module qam_quad_tracker
  import qam_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  advance,
  input  quad_t step,
  output quad_t cur_quad,
  output quad_t next_quad
);
  quad_t quad_q;

  assign next_quad = quad_q + step;
  assign cur_quad  = quad_q;

  always_ff @(posedge clk) begin
    if (rst)          quad_q <= '0;
    else if (advance) quad_q <= next_quad;
  end
endmodule

// File: rtl/qam_point_map.sv
module qam_point_map
  import qam_enc_pkg::*;
#(
  parameter int OUT_W = 8,
  parameter int SCALE = 30
) (
  input  quad_t                    quad,
  input  logic                     fine,
  input  logic [1:0]               inner,
  output logic signed [OUT_W-1:0]  i_val,
  output logic signed [OUT_W-1:0]  q_val
);
  localparam int UW = 3;
  logic signed [UW-1:0] bx, by, rx, ry;

  // point within quadrant 1
  always_comb begin
    bx = 3'sd1;
    by = 3'sd1;
    if (fine) begin
      case (inner)
        2'b00:   begin bx = 3'sd3; by = 3'sd1; end
        2'b01:   begin bx = 3'sd1; by = 3'sd1; end
        2'b11:   begin bx = 3'sd1; by = 3'sd3; end
        default: begin bx = 3'sd3; by = 3'sd3; end
      endcase
    end
  end

  // counterclockwise rotation by quad * 90 degrees
  always_comb begin
    case (quad)
      2'd0:    begin rx = bx;  ry = by;  end
      2'd1:    begin rx = -by; ry = bx;  end
      2'd2:    begin rx = -bx; ry = -by; end
      default: begin rx = by;  ry = -bx; end
    endcase
  end

  assign i_val = OUT_W'(rx * SCALE);
  assign q_val = OUT_W'(ry * SCALE);
endmodule

// File: rtl/qam_quadrant_encoder.sv
module qam_quadrant_encoder
  import qam_enc_pkg::*;
#(
  parameter int SYM_W = 4,
  parameter int OUT_W = 8,
  parameter int SCALE = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic [1:0]       rate_sel,
  input  logic [SYM_W-1:0] sym_bits,
  output logic             out_valid,
  output logic [OUT_W-1:0] i_out,
  output logic [OUT_W-1:0] q_out
);
  quad_t step, cur_quad, next_quad;
  logic  accept, fine;
  logic signed [OUT_W-1:0] i_val, q_val;
  logic take;

  qam_quad_step #(.SYM_W(SYM_W)) u_step (
    .rate(rate_e'(rate_sel)), .sym(sym_bits),
    .step(step), .accept(accept), .fine(fine)
  );

  assign take = sym_valid && accept;

  qam_quad_tracker u_trk (
    .clk(clk), .rst(rst), .advance(take), .step(step),
    .cur_quad(cur_quad), .next_quad(next_quad)
  );

  qam_point_map #(.OUT_W(OUT_W), .SCALE(SCALE)) u_map (
    .quad(next_quad), .fine(fine), .inner(sym_bits[1:0]),
    .i_val(i_val), .q_val(q_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      i_out     <= '0;
      q_out     <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        i_out <= i_val;
        q_out <= q_val;
      end
    end
  end
endmodule

// File: rtl/qam_quadrant_encoder_chk.sv
module qam_quadrant_encoder_chk #(
  parameter int SYM_W = 4,
  parameter int OUT_W = 8,
  parameter int SCALE = 30
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_valid,
  input logic [1:0]       rate_sel,
  input logic [SYM_W-1:0] sym_bits,
  input logic [1:0]       quad,
  input logic             out_valid,
  input logic [OUT_W-1:0] i_out,
  input logic [OUT_W-1:0] q_out
);
  localparam logic [OUT_W-1:0] P1 = OUT_W'(SCALE);
  localparam logic [OUT_W-1:0] N1 = OUT_W'(-SCALE);
  localparam logic [OUT_W-1:0] P3 = OUT_W'(3 * SCALE);
  localparam logic [OUT_W-1:0] N3 = OUT_W'(-3 * SCALE);

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && rate_sel != 2'b11) |=> out_valid); // R7
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> !out_valid && $stable(quad) && $stable(i_out) && $stable(q_out)); // R8
  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && rate_sel == 2'b11) |=> !out_valid && $stable(quad)); // R9
  AST_ZERO_STEP: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && rate_sel == 2'b10 && sym_bits[SYM_W-1:SYM_W-2] == 2'b01) |=> $stable(quad)); // R2
  AST_LEGAL_LEVELS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (i_out == P1 || i_out == N1 || i_out == P3 || i_out == N3) &&
                  (q_out == P1 || q_out == N1 || q_out == P3 || q_out == N3)); // R6
  AST_SIGN_QUADRANT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (i_out[OUT_W-1] == (quad == 2'd1 || quad == 2'd2)) &&
                  (q_out[OUT_W-1] == quad[1])); // R4
  AST_LOW_RATE_INNER: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !rate_sel[1]) |=> (i_out == P1 || i_out == N1) && (q_out == P1 || q_out == N1)); // R5
endmodule

bind qam_quadrant_encoder qam_quadrant_encoder_chk #(
  .SYM_W(SYM_W), .OUT_W(OUT_W), .SCALE(SCALE)
) u_chk (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .rate_sel(rate_sel),
  .sym_bits(sym_bits), .quad(cur_quad), .out_valid(out_valid),
  .i_out(i_out), .q_out(q_out)
);

// File: tb/qam_quadrant_encoder_bench.sv
module qam_quadrant_encoder_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_valid = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic [3:0] sym_bits = 4'h0;
  logic       out_valid;
  logic [7:0] i_out, q_out;

  int checks = 0;
  int failures = 0;
  int model_q = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qam_quadrant_encoder u_qam_quadrant_encoder (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .rate_sel(rate_sel),
    .sym_bits(sym_bits), .out_valid(out_valid), .i_out(i_out), .q_out(q_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dstep(input logic [1:0] d);
    case (d)
      2'b00: return 1;
      2'b01: return 0;
      2'b10: return 2;
      default: return 3;
    endcase
  endfunction

  // send one symbol and check the sample that follows
  task automatic send(input logic [1:0] r, input logic [3:0] b);
    int ux, uy, t, exp_i, exp_q;
    logic signed [7:0] ai, aq;
    string tag;
    @(negedge clk);
    rate_sel = r; sym_bits = b; sym_valid = 1'b1;
    @(negedge clk);
    sym_valid = 1'b0;
    if (r == 2'b11) begin
      check(out_valid == 1'b0, "R9 reserved rate valid", out_valid, 0);
      return;
    end
    case (r)
      2'b00: begin model_q = (model_q + (b[0] ? 3 : 1)) % 4; tag = "R3 one-bit"; end
      2'b01: begin model_q = (model_q + dstep(b[1:0])) % 4; tag = "R10 two-bit"; end
      default: begin model_q = (model_q + dstep(b[3:2])) % 4; tag = "R2 four-bit"; end
    endcase
    ux = 1; uy = 1;
    if (r == 2'b10) begin
      case (b[1:0])
        2'b00: begin ux = 3; uy = 1; end
        2'b01: begin ux = 1; uy = 1; end
        2'b11: begin ux = 1; uy = 3; end
        default: begin ux = 3; uy = 3; end
      endcase
    end
    for (int k = 0; k < model_q; k++) begin
      t = ux; ux = -uy; uy = t;
    end
    exp_i = ux * 30; exp_q = uy * 30;
    ai = i_out; aq = q_out;
    check(out_valid == 1'b1, "R7 out_valid", out_valid, 1);
    check(int'(ai) == exp_i, {tag, " R4 R6 i_out"}, int'(ai), exp_i);
    check(int'(aq) == exp_q, {tag, " R5 R6 q_out"}, int'(aq), exp_q);
  endtask

  initial begin
    logic signed [7:0] hi, hq;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    check(i_out == 8'd0, "R1 reset i_out", i_out, 0);
    check(q_out == 8'd0, "R1 reset q_out", q_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 post-reset valid", out_valid, 0);
    // first symbol from quadrant 1 with zero step: (1,1)*30
    send(2'b01, 4'b0001);
    for (int pass = 0; pass < 4; pass++) begin
      for (int r = 0; r < 4; r++) begin
        for (int b = 0; b < 16; b++) begin
          send(2'(r), 4'(b));
          if (b % 5 == 0) begin
            hi = i_out; hq = q_out;
            sym_bits = 4'(b + 3);
            @(negedge clk);
            check(out_valid == 1'b0, "R8 idle valid", out_valid, 0);
            check(i_out == hi && q_out == hq, "R8 idle hold", int'(signed'(i_out)), int'(hi));
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule